// File: doc/BRIEF.md
# Pixel to Parallel Bus Serializer

This block sits between a pixel stream and the timing engine of a narrow parallel bus that drives a command-mode display panel. Every accepted pixel is cut into one or more bus words, most significant part first. Configuration gives a pixel depth of 12, 16, 18 or 24 bits and a bus of 8, 9, 12 or 16 lines. These two settings fix how the bits are packed: one, two or three words per pixel, or three words for every two pixels. In the last case the middle word carries half a bus of each pixel.

A frame begins when a pixel total, normally width times height, is loaded. The block then takes exactly that many pixels and sends their words. When the last word has been taken it drops its busy flag and gives a single-cycle frame-done pulse. Between frames a single command word can be queued. It goes out with the command/data select bit low. Data words go out with it high. Each word is offered with a request and is held until the timing engine acknowledges it.

Top module: `pix_bus_serializer`

## Requirements
- R1: The depth code (0:12, 1:16, 2:18, 3:24 bits) and the width code (0:8, 1:9, 2:12, 3:16 lines) are latched on `cfg_load` while idle. `cfg_fmt` then reports 0 for one word per pixel, 1 for two, 2 for three and 3 for three words per pixel pair. After reset the setting is 16-bit pixels on 16 lines, format 0.
- R2: A combination is legal when the depth is 1, 2 or 3 times the width, or when twice the depth is 3 times the width. For any other combination `cfg_err` is high and `cfg_fmt` reads 0 until the next accepted `cfg_load`. While `cfg_err` is high, `frame_start` is ignored, `pix_ready` stays low and no data word is requested.
- R3: In formats 0 to 2 a pixel leaves as consecutive width-sized slices, highest slice first. For example, 16 bits on 8 lines sends bits 15:8 then 7:0, and 24 bits on 8 lines sends 23:16, 15:8 then 7:0. Pixel input bits above the depth are ignored.
- R4: In format 3, with first pixel A and second pixel B, the words are: the upper width bits of A; then the remaining half-width of A in the upper half of the word with the top half-width of B below it; then the low width bits of B.
- R5: Bus lines above the configured width are driven to zero whenever `bus_req` is high.
- R6: A word is transferred in a cycle where `bus_req` and `bus_ack` are both high. While `bus_req` is high without `bus_ack`, `bus_word` and `bus_dc` hold their values and `bus_req` stays high.
- R7: `pix_ready` is high only during a frame, while pixels of the frame remain to be taken and no full word is waiting. It is low in the cycle after any accepted pixel.
- R8: `frame_start` while idle loads `frame_total` and raises `busy`. One cycle after every pixel has been accepted and every word taken, `busy` falls and `frame_done` pulses for one cycle. A total of 0 gives the pulse two cycles after the start with no transfer.
- R9: In format 3 a frame with an odd pixel count ends with one word holding the last half-width of the final pixel in its upper half, with zeros below.
- R10: A command word is accepted only while idle with no command pending. It is truncated to the bus width and sent with `bus_dc` low, ahead of any data word. Data words carry `bus_dc` high.
- R11: `cfg_load` and `frame_start` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Latch depth and width codes (idle only) |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_width | input | 2 | Bus width code |
| cfg_fmt | output | 2 | Resulting packing format |
| cfg_err | output | 1 | Latched combination is illegal |
| frame_start | input | 1 | Begin a frame |
| frame_total | input | CNT_W | Pixels in the frame |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | PIX_MAX | Pixel, right-aligned |
| pix_ready | output | 1 | Pixel taken when high with pix_valid |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | BUS_MAX | Command word |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| bus_req | output | 1 | Word waiting for the timing engine |
| bus_ack | input | 1 | Timing engine takes the word |
| bus_word | output | BUS_MAX | Word to drive on the bus |
| bus_dc | output | 1 | 1 data word, 0 command word |

## Verification
Two situations are provoked in the same cycle. In the first, a command and a frame start are presented on the same edge. The scoreboard then expects the command word before the first data word, with `bus_dc` low on it. In the second, a command is offered while a frame is still draining under a random acknowledge pattern. Here `cmd_ready` must stay low until the frame has ended, and the command word must follow the final data word. The frame-done pulse must only arrive once the scoreboard queue of the frame's words is empty.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic [1:0] {
      FMT_ONE   = 2'd0,
      FMT_TWO   = 2'd1,
      FMT_THREE = 2'd2,
      FMT_PAIR  = 2'd3
   } fmt_e;

   function automatic int pix_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 12;
         2'd1:    return 16;
         2'd2:    return 18;
         default: return 24;
      endcase
   endfunction

   function automatic int bus_lines(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 9;
         2'd2:    return 12;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/pbs_fmt_decode.sv
module pbs_fmt_decode
   import pbs_pkg::*;
#(
   parameter int AV_W = 6
) (
   input  logic [1:0]      depth_code,
   input  logic [1:0]      width_code,
   output logic            legal,
   output fmt_e            fmt,
   output logic [AV_W-1:0] d_bits,
   output logic [AV_W-1:0] w_bits
);

   always_comb begin
      int d;
      int w;
      d      = pix_bits(depth_code);
      w      = bus_lines(width_code);
      d_bits = AV_W'(d);
      w_bits = AV_W'(w);
      legal  = 1'b0;
      fmt    = FMT_ONE;
      if ((d % w) == 0) begin
         case (d / w)
            1: begin legal = 1'b1; fmt = FMT_ONE;   end
            2: begin legal = 1'b1; fmt = FMT_TWO;   end
            3: begin legal = 1'b1; fmt = FMT_THREE; end
            default: ;
         endcase
      end else if (((2 * d) % w) == 0 && ((2 * d) / w) == 3) begin
         legal = 1'b1;
         fmt   = FMT_PAIR;
      end
   end

endmodule

// File: rtl/pbs_packer.sv
module pbs_packer
   import pbs_pkg::*;
#(
   parameter int PIX_MAX = 24,
   parameter int BUS_MAX = 16,
   parameter int AV_W    = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         width_code,
   input  logic [AV_W-1:0]    d_bits,
   input  logic [AV_W-1:0]    w_bits,
   input  logic               accept,
   input  logic [PIX_MAX-1:0] pix,
   input  logic               take,
   output logic               has_word,
   output logic               empty,
   output logic [BUS_MAX-1:0] word,
   output logic [BUS_MAX-1:0] mask
);

   localparam int SH_W = 2 * PIX_MAX;

   logic [SH_W-1:0]    sh_q, sh_n, ins;
   logic [AV_W-1:0]    avail_q, avail_n, lj_sh;
   logic [PIX_MAX-1:0] pix_lj;
   logic [BUS_MAX-1:0] slice [4];
   logic [BUS_MAX-1:0] msk   [4];

   // one output lane per supported bus width
   generate
      for (genvar g = 0; g < 4; g++) begin : g_lane
         localparam int WG = bus_lines(2'(g));
         assign slice[g] = BUS_MAX'(sh_q[SH_W-1 -: WG]);
         assign msk[g]   = BUS_MAX'({WG{1'b1}});
      end
   endgenerate

   assign word     = slice[width_code];
   assign mask     = msk[width_code];
   assign has_word = (avail_q >= w_bits);
   assign empty    = (avail_q == '0);

   // left-justify the pixel, dropping bits above the depth
   assign lj_sh  = AV_W'(PIX_MAX) - d_bits;
   assign pix_lj = pix << lj_sh;
   assign ins    = {pix_lj, {PIX_MAX{1'b0}}} >> avail_q;

   always_comb begin
      sh_n    = sh_q;
      avail_n = avail_q;
      if (take) begin
         sh_n    = sh_q << w_bits;
         avail_n = has_word ? (avail_q - w_bits) : '0;
      end
      if (accept) begin
         sh_n    = sh_n | ins;
         avail_n = avail_n + d_bits;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         avail_q <= '0;
      end else begin
         sh_q    <= sh_n;
         avail_q <= avail_n;
      end
   end

endmodule

// File: rtl/pbs_frame_ctl.sv
module pbs_frame_ctl #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic [CNT_W-1:0] total,
   input  logic             accept,
   input  logic             drained,
   output logic             en,
   output logic             last,
   output logic             done
);

   logic [CNT_W-1:0] left_q;

   assign last = (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         done   <= 1'b0;
         left_q <= '0;
      end else begin
         done <= 1'b0;
         if (start_ok) begin
            en     <= 1'b1;
            left_q <= total;
         end else if (en && last && drained) begin
            en   <= 1'b0;
            done <= 1'b1;
         end else if (accept) begin
            left_q <= left_q - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/pix_bus_serializer.sv
module pix_bus_serializer
   import pbs_pkg::*;
#(
   parameter int PIX_MAX = 24,
   parameter int BUS_MAX = 16,
   parameter int CNT_W   = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [1:0]         cfg_depth,
   input  logic [1:0]         cfg_width,
   output logic [1:0]         cfg_fmt,
   output logic               cfg_err,
   input  logic               frame_start,
   input  logic [CNT_W-1:0]   frame_total,
   output logic               busy,
   output logic               frame_done,
   input  logic               pix_valid,
   input  logic [PIX_MAX-1:0] pix_data,
   output logic               pix_ready,
   input  logic               cmd_valid,
   input  logic [BUS_MAX-1:0] cmd_data,
   output logic               cmd_ready,
   output logic               bus_req,
   input  logic               bus_ack,
   output logic [BUS_MAX-1:0] bus_word,
   output logic               bus_dc
);

   localparam int SH_W = 2 * PIX_MAX;
   localparam int AV_W = $clog2(SH_W + 1);

   generate
      if (PIX_MAX < 24 || BUS_MAX < 16 || CNT_W < 1) begin : g_bad_params
         $error("pix_bus_serializer: PIX_MAX>=24, BUS_MAX>=16, CNT_W>=1 required");
      end
   endgenerate

   logic [1:0]         dcode_q, wcode_q;
   logic               legal;
   fmt_e               fmt;
   logic [AV_W-1:0]    d_bits, w_bits;
   logic               en, last, has_word, empty, flush;
   logic               accept, take, start_ok, cmd_pend;
   logic [BUS_MAX-1:0] data_word, lane_mask, cmd_q;

   pbs_fmt_decode #(.AV_W(AV_W)) u_dec (
      .depth_code (dcode_q),
      .width_code (wcode_q),
      .legal      (legal),
      .fmt        (fmt),
      .d_bits     (d_bits),
      .w_bits     (w_bits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dcode_q <= 2'd1;
         wcode_q <= 2'd3;
      end else if (cfg_load && !en) begin
         dcode_q <= cfg_depth;
         wcode_q <= cfg_width;
      end
   end

   assign cfg_fmt = fmt;
   assign cfg_err = !legal;

   assign start_ok  = frame_start && !en && legal;
   assign pix_ready = en && !last && !has_word;
   assign accept    = pix_valid && pix_ready;
   assign flush     = en && last && !empty && !has_word;
   assign take      = bus_ack && !cmd_pend && (has_word || flush);

   pbs_frame_ctl #(.CNT_W(CNT_W)) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .total    (frame_total),
      .accept   (accept),
      .drained  (empty && !cmd_pend),
      .en       (en),
      .last     (last),
      .done     (frame_done)
   );

   pbs_packer #(.PIX_MAX(PIX_MAX), .BUS_MAX(BUS_MAX), .AV_W(AV_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .width_code (wcode_q),
      .d_bits     (d_bits),
      .w_bits     (w_bits),
      .accept     (accept),
      .pix        (pix_data),
      .take       (take),
      .has_word   (has_word),
      .empty      (empty),
      .word       (data_word),
      .mask       (lane_mask)
   );

   // single command slot, served ahead of data words
   assign cmd_ready = !en && !cmd_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_pend <= 1'b0;
         cmd_q    <= '0;
      end else if (cmd_valid && cmd_ready) begin
         cmd_pend <= 1'b1;
         cmd_q    <= cmd_data & lane_mask;
      end else if (cmd_pend && bus_ack) begin
         cmd_pend <= 1'b0;
      end
   end

   assign busy     = en;
   assign bus_req  = cmd_pend || has_word || flush;
   assign bus_word = cmd_pend ? cmd_q : data_word;
   assign bus_dc   = !cmd_pend;

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker
   import pbs_pkg::*;
#(
   parameter int BUS_MAX = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_valid,
   input logic               pix_ready,
   input logic               busy,
   input logic               cfg_err,
   input logic               frame_done,
   input logic               cmd_ready,
   input logic               bus_req,
   input logic               bus_ack,
   input logic [BUS_MAX-1:0] bus_word,
   input logic               bus_dc,
   input logic [1:0]         wcode
);

   p_err_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!pix_ready && !busy));

   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ((bus_word >> bus_lines(wcode)) == '0));

   p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_word) && $stable(bus_dc)));

   p_ready_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |-> busy);

   p_gap_after_pixel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready) |=> !pix_ready);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!busy ##1 !frame_done));

   p_cmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !busy);

endmodule

bind pix_bus_serializer pbs_checker #(.BUS_MAX(BUS_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_valid  (pix_valid),
   .pix_ready  (pix_ready),
   .busy       (busy),
   .cfg_err    (cfg_err),
   .frame_done (frame_done),
   .cmd_ready  (cmd_ready),
   .bus_req    (bus_req),
   .bus_ack    (bus_ack),
   .bus_word   (bus_word),
   .bus_dc     (bus_dc),
   .wcode      (wcode_q)
);

// File: tb/sim_pix_bus_serializer.sv
module sim_pix_bus_serializer;

   localparam int CLK_PERIOD = 10;
   localparam int PIX_MAX = 24;
   localparam int BUS_MAX = 16;
   localparam int CNT_W   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [1:0] cfg_depth = '0, cfg_width = '0;
   logic [1:0] cfg_fmt;
   logic cfg_err, busy, frame_done, pix_ready, cmd_ready, bus_req, bus_dc;
   logic frame_start = 1'b0;
   logic [CNT_W-1:0] frame_total = '0;
   logic pix_valid = 1'b0;
   logic [PIX_MAX-1:0] pix_data = '0;
   logic cmd_valid = 1'b0;
   logic [BUS_MAX-1:0] cmd_data = '0;
   logic bus_ack = 1'b0;
   logic [BUS_MAX-1:0] bus_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   pix_bus_serializer #(.PIX_MAX(PIX_MAX), .BUS_MAX(BUS_MAX), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_depth(cfg_depth),
      .cfg_width(cfg_width), .cfg_fmt(cfg_fmt), .cfg_err(cfg_err),
      .frame_start(frame_start), .frame_total(frame_total), .busy(busy),
      .frame_done(frame_done), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_ready(pix_ready), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .bus_req(bus_req), .bus_ack(bus_ack),
      .bus_word(bus_word), .bus_dc(bus_dc)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [16:0] exp_q[$];
   bit bitq[$];
   int m_d = 16, m_w = 16;
   bit ack_rand = 1'b0;
   bit held_v = 1'b0;
   logic [16:0] held = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // expected {legal, fmt} per {depth code, width code}
   function automatic logic [2:0] exp_cfg(input logic [3:0] c);
      case (c)
         4'b0000: return 3'b111;  // 12 on 8
         4'b0010: return 3'b100;  // 12 on 12
         4'b0100: return 3'b101;  // 16 on 8
         4'b0111: return 3'b100;  // 16 on 16
         4'b1001: return 3'b101;  // 18 on 9
         4'b1010: return 3'b111;  // 18 on 12
         4'b1100: return 3'b110;  // 24 on 8
         4'b1110: return 3'b101;  // 24 on 12
         4'b1111: return 3'b111;  // 24 on 16
         default: return 3'b000;
      endcase
   endfunction

   function automatic int dtab(input logic [1:0] c);
      case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
   endfunction

   function automatic int wtab(input logic [1:0] c);
      case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
   endfunction

   // pop one word from the bit stream, zero filled below if short
   task automatic pop_word();
      logic [15:0] wd = '0;
      for (int j = 0; j < m_w; j++) begin
         wd = wd << 1;
         if (bitq.size() > 0) wd[0] = bitq.pop_front();
      end
      exp_q.push_back({1'b1, wd});
   endtask

   task automatic model_pixel(input logic [23:0] p, input bit final_px);
      for (int b = m_d - 1; b >= 0; b--) bitq.push_back(p[b]);
      while (bitq.size() >= m_w) pop_word();
      if (final_px && bitq.size() > 0) pop_word();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         bus_ack = ack_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
         if (held_v)
            chk(bus_req && ({bus_dc, bus_word} == held), "R6 word held until ack",
                {15'd0, bus_req, bus_dc, bus_word}, {15'd1, held});
         held_v = bus_req && !bus_ack;
         held   = {bus_dc, bus_word};
         if (bus_req && bus_ack) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3/R4/R10 unexpected word", {15'd0, bus_dc, bus_word}, 32'd0);
            end else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               chk({bus_dc, bus_word} == e, "R3/R4/R5/R9/R10 bus word",
                   {15'd0, bus_dc, bus_word}, {15'd0, e});
            end
         end
      end
   end

   task automatic cfg_pulse(input logic [1:0] d, input logic [1:0] w);
      cfg_depth = d; cfg_width = w; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic do_cfg(input logic [1:0] d, input logic [1:0] w);
      cfg_pulse(d, w);
      m_d = dtab(d); m_w = wtab(w);
   endtask

   task automatic start_frame(input int n);
      frame_total = CNT_W'(n); frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic feed(input int n);
      for (int i = 0; i < n; i++) begin
         pix_data = 24'($urandom); pix_valid = 1'b1;
         while (!pix_ready) @(negedge clk);
         model_pixel(pix_data, i == n - 1);
         @(negedge clk);
         chk(!pix_ready, "R7 ready low after accept", {31'd0, pix_ready}, 32'd0);
      end
      pix_valid = 1'b0;
   endtask

   task automatic wait_done();
      bit seen = 1'b0;
      for (int k = 0; k < 3000 && !seen; k++) begin
         if (frame_done) seen = 1'b1;
         else @(negedge clk);
      end
      chk(seen, "R8 frame_done seen", {31'd0, seen}, 32'd1);
      chk(exp_q.size() == 0, "R8 words all sent before done", exp_q.size(), 32'd0);
      chk(!busy, "R8 busy clear at done", {31'd0, busy}, 32'd0);
   endtask

   task automatic send_cmd(input logic [15:0] c);
      logic [15:0] m;
      m = 16'((32'd1 << m_w) - 1);
      cmd_data = c; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      chk(!busy, "R10 command only taken while idle", {31'd0, busy}, 32'd0);
      exp_q.push_back({1'b0, c & m});
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cfg_fmt == 2'd0 && !cfg_err, "R1 reset format", {29'd0, cfg_err, cfg_fmt}, 32'd0);
      chk(!pix_ready && !bus_req && !busy && !frame_done && cmd_ready,
          "R8 reset idle", {27'd0, pix_ready, bus_req, busy, frame_done, cmd_ready}, 32'd1);

      // every configuration: format, error, and a five-pixel frame
      for (int c = 0; c < 16; c++) begin
         logic [2:0] e;
         e = exp_cfg(4'(c));
         do_cfg(2'(c >> 2), 2'(c));
         chk(cfg_fmt == e[1:0], "R1 cycle format", {30'd0, cfg_fmt}, {30'd0, e[1:0]});
         chk(cfg_err == !e[2], "R2 error flag", {31'd0, cfg_err}, {31'd0, !e[2]});
         ack_rand = c[0];
         if (e[2]) begin
            start_frame(5);
            feed(5);
            wait_done();
         end else begin
            bit quiet = 1'b1;
            frame_total = 20'd4; frame_start = 1'b1; pix_valid = 1'b1;
            for (int k = 0; k < 8; k++) begin
               @(negedge clk);
               if (busy || pix_ready || bus_req) quiet = 1'b0;
            end
            frame_start = 1'b0; pix_valid = 1'b0;
            chk(quiet, "R2 illegal setting blocks frame", {31'd0, quiet}, 32'd1);
         end
      end

      // zero pixel total
      do_cfg(2'd1, 2'd0);
      ack_rand = 1'b0;
      start_frame(0);
      chk(busy && !frame_done, "R8 zero total busy", {30'd0, busy, frame_done}, 32'd2);
      @(negedge clk);
      chk(frame_done && !busy, "R8 zero total done", {30'd0, busy, frame_done}, 32'd1);
      chk(exp_q.size() == 0, "R8 zero total no words", exp_q.size(), 32'd0);

      // config and restart ignored during a frame
      start_frame(3);
      cfg_pulse(2'd3, 2'd3);
      chk(cfg_fmt == 2'd1, "R11 cfg_load ignored while busy", {30'd0, cfg_fmt}, 32'd1);
      frame_total = 20'd9; frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      feed(3);
      wait_done();
      repeat (2) @(negedge clk);
      chk(!busy, "R11 frame_start ignored while busy", {31'd0, busy}, 32'd0);

      // command and frame start on the same edge, pair format
      do_cfg(2'd3, 2'd3);
      ack_rand = 1'b1;
      exp_q.push_back({1'b0, 16'hBEEF});
      cmd_data = 16'hBEEF; cmd_valid = 1'b1;
      frame_total = 20'd4; frame_start = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; frame_start = 1'b0;
      feed(4);
      wait_done();

      // command offered while a frame drains, narrow bus truncation
      do_cfg(2'd0, 2'd0);
      start_frame(7);
      fork
         feed(7);
         begin
            repeat (3) @(negedge clk);
            chk(!cmd_ready, "R10 command blocked during frame", {31'd0, cmd_ready}, 32'd0);
            send_cmd(16'hABCD);
         end
      join
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R10 command sent after frame", exp_q.size(), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule